// File: doc/BRIEF.md
# Dual-Channel OS Timer

This peripheral gives a processor two timing services from one shared input tick stream. The first channel is a one-shot event timer. Software loads a compare value, clears and starts the channel. The channel counts prescaled ticks until its counter equals the compare value, then stops and raises a compare flag. The flag drives an interrupt line unless it is masked. The second channel is a free-running counter that serves as a system time base. It counts prescaled ticks and wraps around.

The block sits behind a simple word-addressed register bus with address, write strobe, read strobe, write data and combinational read data. Each channel has its own two-bit power-of-four prescaler. Enables use separate write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write to start or stop a channel. The `ext_tick` input is a one-cycle-wide strobe, synchronous to `clk`, and marks each pulse of the shared input clock.

Top module: `os_timer`

## Requirements
- R1: After reset every register reads 0, both channels are stopped, the compare flag is clear, the interrupt is unmasked, and `evt_irq` is low.
- R2: Writing 1 to bit 0 or bit 1 at offset 0x34 starts channel 1 or channel 2. Writing 1 to the same bit at offset 0x38 stops that channel. Zero bits change nothing. Both offsets read back the enable bits in [1:0].
- R3: Offset 0x00 holds the prescale selects, bits [1:0] for channel 1 and bits [3:2] for channel 2. An enabled channel ticks once every 1, 4 or 16 `ext_tick` pulses for a select of 0, 1 or 2, and a select of 3 acts as 16. A new select is picked up when the current division period completes, or at any cycle while the channel is stopped. A stopped channel restarts its division period from zero.
- R4: Writing 1 to bit 0 or bit 1 at offset 0x08 zeroes the channel-1 or channel-2 counter. Zero bits have no effect, and the offset reads 0.
- R5: An enabled channel 1 advances its counter (offset 0x18) by one per tick until it equals the compare value (offset 0x14), and then holds. The tick that makes the counter equal the compare value sets the flag.
- R6: The flag is bit 0 of offset 0x0C. Writing 0 there clears it and writing 1 has no effect. A flag set by hardware in the same cycle wins over the clear.
- R7: Bit 0 of offset 0x10 is the interrupt mask, with 1 meaning masked. `evt_irq` is high exactly while the flag is set and the mask is clear.
- R8: Channel 2 is a 32-bit counter at offset 0x20. It advances once per tick while enabled and wraps from 0xFFFFFFFF to 0.
- R9: A read of offset 0x20 with `bus_re` high latches the counter bits above bit 31 into the high buffer at offset 0x24. With a 32-bit counter the buffer reads 0.
- R10: A bus write to offset 0x18 or 0x20 loads that counter. A load in the same cycle as a tick wins, and a load never sets the flag.
- R11: Reads of any other offset return 0, and writes to them change no register.
- R12: Channel 1 reaches and flags compare values up to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | One pulse per period of the shared input clock |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; used only to latch the high buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_irq | output | 1 | Channel-1 compare interrupt |

## Verification
The bench first runs directed sequences. A compare of 4 checks that the flag appears on exactly the fourth tick. A compare of 0xFFFFFFFF with a preloaded counter shows the full compare range, and a preloaded channel 2 separates a true wrap from a saturating counter. After that, long seeded random traffic mixes writes to every offset, including unused ones, with sparse `ext_tick` pulses and changing prescale selects. A cycle model predicts every read and the interrupt on every cycle. This random phase separates period-boundary prescale switching from immediate switching. It also shows that a set wins over a same-cycle flag clear and that a load wins over a same-cycle tick.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned NUM_CH  = 2;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned MAX_SEL = 2;
   localparam int unsigned DIV_W   = 2 * MAX_SEL;

   localparam logic [7:0] OFF_PSC     = 8'h00;
   localparam logic [7:0] OFF_ZERO    = 8'h08;
   localparam logic [7:0] OFF_FLAG    = 8'h0C;
   localparam logic [7:0] OFF_MASK    = 8'h10;
   localparam logic [7:0] OFF_CMP     = 8'h14;
   localparam logic [7:0] OFF_EVCNT   = 8'h18;
   localparam logic [7:0] OFF_BASE_LO = 8'h20;
   localparam logic [7:0] OFF_BASE_HI = 8'h24;
   localparam logic [7:0] OFF_RUN_SET = 8'h34;
   localparam logic [7:0] OFF_RUN_CLR = 8'h38;

   localparam int unsigned CH_EVT  = 0;
   localparam int unsigned CH_BASE = 1;
endpackage

// File: rtl/ostmr_prescaler.sv
module ostmr_prescaler
   import ostmr_pkg::*;
#(
   parameter int unsigned P_SEL_W   = SEL_W,
   parameter int unsigned P_MAX_SEL = MAX_SEL
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               ext_tick,
   input  logic [P_SEL_W-1:0] sel_req,
   output logic               tick
);
   localparam int unsigned L_DIV_W = (2 * P_MAX_SEL > 0) ? 2 * P_MAX_SEL : 1;

   if (P_MAX_SEL >= (1 << P_SEL_W)) begin : g_bad_sel
      $error("ostmr_prescaler: P_MAX_SEL does not fit in P_SEL_W");
   end

   function automatic logic [L_DIV_W-1:0] period_last(input logic [P_SEL_W-1:0] s);
      int unsigned         eff;
      logic [L_DIV_W:0]    full;
      eff  = (int'(s) > int'(P_MAX_SEL)) ? P_MAX_SEL : int'(s);
      full = (L_DIV_W+1)'(1) << (2 * eff);
      return L_DIV_W'(full - 1'b1);
   endfunction

   logic [L_DIV_W-1:0] div_q;
   logic [P_SEL_W-1:0] act_q;
   logic [L_DIV_W-1:0] last;

   assign last = period_last(act_q);
   assign tick = run & ext_tick & (div_q == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         act_q <= '0;
      end else if (!run) begin
         div_q <= '0;
         act_q <= sel_req;
      end else if (ext_tick) begin
         if (div_q == last) begin
            div_q <= '0;
            act_q <= sel_req;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      div_q <= period_last(act_q)); // R3
   AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> div_q == '0); // R3
endmodule

// File: rtl/ostmr_event_chan.sv
module ostmr_event_chan #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         zero,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         cmp_we,
   input  logic [W-1:0] cmp_val,
   input  logic         flag_clr,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cmp,
   output logic         flag
);
   if (W < 3) begin : g_bad_w
      $error("ostmr_event_chan: W too small for a compare of 4");
   end

   logic         step;
   logic         reach;
   logic [W-1:0] cnt_inc;

   assign cnt_inc = cnt + W'(1);
   assign step    = tick & ~zero & ~load & (cnt != cmp);
   assign reach   = step & (cnt_inc == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         cmp  <= '0;
         flag <= 1'b0;
      end else begin
         if (zero)      cnt <= '0;
         else if (load) cnt <= load_val;
         else if (step) cnt <= cnt_inc;

         if (cmp_we) cmp <= cmp_val;

         if (reach)         flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   AST_FLAG_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> cnt == $past(cmp)); // R5
   AST_HOLD_AT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == cmp && !zero && !load) |=> $stable(cnt)); // R5
   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !zero && !load) |=> $stable(cnt)); // R5
endmodule

// File: rtl/ostmr_free_cnt.sv
module ostmr_free_cnt
   import ostmr_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             zero,
   input  logic             load_lo,
   input  logic [BUS_W-1:0] lo_val,
   input  logic             snap,
   output logic [W-1:0]     cnt,
   output logic [BUS_W-1:0] hi_buf
);
   if (W < BUS_W || W > 2 * BUS_W) begin : g_bad_w
      $error("ostmr_free_cnt: W must lie between one and two bus words");
   end

   logic [W-1:0] load_word;

   if (W > BUS_W) begin : g_wide
      logic [BUS_W-1:0] hi_q;
      assign load_word = {cnt[W-1:BUS_W], lo_val};
      always_ff @(posedge clk) begin
         if (!rst_n)    hi_q <= '0;
         else if (snap) hi_q <= BUS_W'(cnt[W-1:BUS_W]);
      end
      assign hi_buf = hi_q;
   end else begin : g_narrow
      assign load_word = lo_val[W-1:0];
      assign hi_buf    = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (zero)    cnt <= '0;
      else if (load_lo) cnt <= load_word;
      else if (tick)    cnt <= cnt + W'(1);
   end

   AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !zero && !load_lo) |=> cnt == $past(cnt) + W'(1)); // R8
   AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !zero && !load_lo) |=> $stable(cnt)); // R8
endmodule

// File: rtl/os_timer.sv
module os_timer
   import ostmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned EVT_W  = 32,
   parameter int unsigned BASE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              evt_irq
);
   localparam int unsigned PSC_BITS = NUM_CH * SEL_W;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("os_timer: ADDR_W cannot reach the highest offset");
   end
   if (EVT_W != BUS_W) begin : g_bad_evt
      $error("os_timer: event counter must be one bus word");
   end

   localparam logic [ADDR_W-1:0] A_PSC     = ADDR_W'(OFF_PSC);
   localparam logic [ADDR_W-1:0] A_ZERO    = ADDR_W'(OFF_ZERO);
   localparam logic [ADDR_W-1:0] A_FLAG    = ADDR_W'(OFF_FLAG);
   localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_CMP     = ADDR_W'(OFF_CMP);
   localparam logic [ADDR_W-1:0] A_EVCNT   = ADDR_W'(OFF_EVCNT);
   localparam logic [ADDR_W-1:0] A_BASE_LO = ADDR_W'(OFF_BASE_LO);
   localparam logic [ADDR_W-1:0] A_BASE_HI = ADDR_W'(OFF_BASE_HI);
   localparam logic [ADDR_W-1:0] A_RUN_SET = ADDR_W'(OFF_RUN_SET);
   localparam logic [ADDR_W-1:0] A_RUN_CLR = ADDR_W'(OFF_RUN_CLR);

   logic [PSC_BITS-1:0] psc_q;
   logic [NUM_CH-1:0]   run_q;
   logic                mask_q;
   logic [NUM_CH-1:0]   tick_ch;
   logic [NUM_CH-1:0]   run_set;
   logic [NUM_CH-1:0]   run_clr;
   logic [NUM_CH-1:0]   zero_ch;

   logic             wr_psc, wr_mask, wr_cmp, wr_evcnt, wr_base, wr_flag;
   logic [EVT_W-1:0] evt_cnt, evt_cmp;
   logic             evt_flag;
   logic [BASE_W-1:0] base_cnt;
   logic [BUS_W-1:0] base_hi;

   assign wr_psc   = bus_we & (bus_addr == A_PSC);
   assign wr_mask  = bus_we & (bus_addr == A_MASK);
   assign wr_cmp   = bus_we & (bus_addr == A_CMP);
   assign wr_evcnt = bus_we & (bus_addr == A_EVCNT);
   assign wr_base  = bus_we & (bus_addr == A_BASE_LO);
   assign wr_flag  = bus_we & (bus_addr == A_FLAG);

   assign run_set = (bus_we && bus_addr == A_RUN_SET) ? bus_wdata[NUM_CH-1:0] : '0;
   assign run_clr = (bus_we && bus_addr == A_RUN_CLR) ? bus_wdata[NUM_CH-1:0] : '0;
   assign zero_ch = (bus_we && bus_addr == A_ZERO)    ? bus_wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psc_q  <= '0;
         run_q  <= '0;
         mask_q <= 1'b0;
      end else begin
         if (wr_psc)  psc_q  <= bus_wdata[PSC_BITS-1:0];
         if (wr_mask) mask_q <= bus_wdata[0];
         run_q <= (run_q | run_set) & ~run_clr;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_psc
      ostmr_prescaler #(.P_SEL_W(SEL_W), .P_MAX_SEL(MAX_SEL)) u_psc (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run_q[c]),
         .ext_tick (ext_tick),
         .sel_req  (psc_q[c*SEL_W +: SEL_W]),
         .tick     (tick_ch[c])
      );
   end

   ostmr_event_chan #(.W(EVT_W)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ch[CH_EVT]),
      .zero     (zero_ch[CH_EVT]),
      .load     (wr_evcnt),
      .load_val (bus_wdata),
      .cmp_we   (wr_cmp),
      .cmp_val  (bus_wdata),
      .flag_clr (wr_flag & ~bus_wdata[0]),
      .cnt      (evt_cnt),
      .cmp      (evt_cmp),
      .flag     (evt_flag)
   );

   ostmr_free_cnt #(.W(BASE_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_ch[CH_BASE]),
      .zero    (zero_ch[CH_BASE]),
      .load_lo (wr_base),
      .lo_val  (bus_wdata),
      .snap    (bus_re & (bus_addr == A_BASE_LO)),
      .cnt     (base_cnt),
      .hi_buf  (base_hi)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_PSC:     bus_rdata[PSC_BITS-1:0] = psc_q;
         A_FLAG:    bus_rdata[0]            = evt_flag;
         A_MASK:    bus_rdata[0]            = mask_q;
         A_CMP:     bus_rdata               = evt_cmp;
         A_EVCNT:   bus_rdata               = evt_cnt;
         A_BASE_LO: bus_rdata               = base_cnt[BUS_W-1:0];
         A_BASE_HI: bus_rdata               = base_hi;
         A_RUN_SET,
         A_RUN_CLR: bus_rdata[NUM_CH-1:0]   = run_q;
         default:   bus_rdata               = '0;
      endcase
   end

   assign evt_irq = evt_flag & ~mask_q;

   AST_RUN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_RUN_SET && bus_wdata[0]) |=> run_q[0]); // R2
   AST_RUN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_RUN_CLR && bus_wdata[1]) |=> !run_q[1]); // R2
   AST_STOPPED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[CH_BASE] |-> !tick_ch[CH_BASE]); // R2
   AST_ZERO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_ZERO && bus_wdata[0]) |=> evt_cnt == '0); // R4
endmodule

// File: tb/tb_os_timer.sv
module tb_os_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        evt_irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   os_timer dut (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_irq(evt_irq)
   );

   // reference state, built from the requirements
   logic [3:0]  m_psc;
   logic [1:0]  m_run;
   logic [31:0] m_cnt1, m_cmp, m_cnt2, m_hi;
   logic        m_flag, m_mask;
   int          m_div [2];
   logic [1:0]  m_act [2];

   function automatic int last_of(input logic [1:0] s);
      if (s == 2'd0) return 0;
      if (s == 2'd1) return 3;
      return 15;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return {28'd0, m_psc};
         8'h0C: return {31'd0, m_flag};
         8'h10: return {31'd0, m_mask};
         8'h14: return m_cmp;
         8'h18: return m_cnt1;
         8'h20: return m_cnt2;
         8'h24: return m_hi;
         8'h34, 8'h38: return {30'd0, m_run};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h00: return "R3";
         8'h08: return "R4";
         8'h0C: return "R6";
         8'h10: return "R7";
         8'h14, 8'h18: return "R5";
         8'h20: return "R8";
         8'h24: return "R9";
         8'h34, 8'h38: return "R2";
         default: return "R11";
      endcase
   endfunction

   task automatic model_reset();
      m_psc = '0; m_run = '0; m_cnt1 = '0; m_cmp = '0; m_cnt2 = '0;
      m_hi = '0; m_flag = 1'b0; m_mask = 1'b0;
      for (int c = 0; c < 2; c++) begin m_div[c] = 0; m_act[c] = '0; end
   endtask

   task automatic model_step(input logic [7:0] a, input logic we, input logic re,
                             input logic [31:0] d, input logic tk);
      logic [1:0] tck;
      logic [1:0] zero;
      logic       adv;
      for (int c = 0; c < 2; c++) begin
         tck[c] = m_run[c] && tk && (m_div[c] == last_of(m_act[c]));
         if (!m_run[c]) begin
            m_div[c] = 0; m_act[c] = m_psc[c*2 +: 2];
         end else if (tk) begin
            if (m_div[c] == last_of(m_act[c])) begin
               m_div[c] = 0; m_act[c] = m_psc[c*2 +: 2];
            end else m_div[c] = m_div[c] + 1;
         end
      end
      zero = (we && a == 8'h08) ? d[1:0] : 2'b00;
      // R10, R5, R12: load wins over tick, counter holds at compare
      adv = tck[0] && !zero[0] && !(we && a == 8'h18) && (m_cnt1 != m_cmp);
      if (adv && (m_cnt1 + 32'd1 == m_cmp)) m_flag = 1'b1;
      else if (we && a == 8'h0C && !d[0]) m_flag = 1'b0;
      if (zero[0]) m_cnt1 = '0;
      else if (we && a == 8'h18) m_cnt1 = d;
      else if (adv) m_cnt1 = m_cnt1 + 32'd1;
      if (zero[1]) m_cnt2 = '0;
      else if (we && a == 8'h20) m_cnt2 = d;
      else if (tck[1]) m_cnt2 = m_cnt2 + 32'd1;
      if (re && a == 8'h20) m_hi = 32'd0;   // R9: 32-bit counter, no upper bits
      if (we && a == 8'h14) m_cmp = d;
      if (we && a == 8'h00) m_psc = d[3:0];
      if (we && a == 8'h10) m_mask = d[0];
      if (we && a == 8'h34) m_run = m_run | d[1:0];
      if (we && a == 8'h38) m_run = m_run & ~d[1:0];
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic [7:0] a, input logic we, input logic re,
                      input logic [31:0] d, input logic tk);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_re = re; bus_wdata = d; ext_tick = tk;
      #1;
      chk(tag_of(a), bus_rdata, m_read(a));
      chk("R7", {31'd0, evt_irq}, {31'd0, m_flag & ~m_mask});
      @(posedge clk);
      model_step(a, we, re, d, tk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(a, 1'b1, 1'b0, d, 1'b0);
   endtask

   task automatic idle(input int n, input logic tk);
      for (int i = 0; i < n; i++) cyc(8'h18, 1'b0, 1'b0, 32'd0, tk);
   endtask

   logic [7:0] offs [12];
   initial begin
      offs = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
               8'h20, 8'h24, 8'h34, 8'h38, 8'h04, 8'h3C};
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: every register reads zero after reset
      for (int i = 0; i < 12; i++) begin
         cyc(offs[i], 1'b0, 1'b0, 32'd0, 1'b0);
         chk("R1", bus_rdata, 32'd0);
      end
      chk("R1", {31'd0, evt_irq}, 32'd0);

      // R5: compare of 4, flag exactly on the fourth tick
      wr(8'h14, 32'd4);
      wr(8'h34, 32'h1);
      idle(3, 1'b1);
      #1 chk("R5", {31'd0, evt_irq}, 32'd0);
      idle(1, 1'b1);
      #1 chk("R5", {31'd0, evt_irq}, 32'd1);
      idle(2, 1'b1);
      cyc(8'h18, 1'b0, 1'b0, 0, 1'b0);
      chk("R5", bus_rdata, 32'd4);
      // R6: writing 1 leaves flag, writing 0 clears
      wr(8'h0C, 32'h1);
      #1 chk("R6", {31'd0, evt_irq}, 32'd1);
      wr(8'h0C, 32'h0);
      #1 chk("R6", {31'd0, evt_irq}, 32'd0);

      // R12: maximum compare
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFD);
      idle(2, 1'b1);
      #1 chk("R12", {31'd0, evt_irq}, 32'd1);
      wr(8'h10, 32'h1);
      #1 chk("R7", {31'd0, evt_irq}, 32'd0);
      wr(8'h10, 32'h0);
      wr(8'h0C, 32'h0);

      // R8: wrap of the time base; R9: high buffer stays zero
      wr(8'h20, 32'hFFFF_FFFE);
      wr(8'h34, 32'h2);
      idle(3, 1'b1);
      cyc(8'h20, 1'b0, 1'b1, 0, 1'b0);
      chk("R8", bus_rdata, 32'd1);
      cyc(8'h24, 1'b0, 1'b0, 0, 1'b0);
      chk("R9", bus_rdata, 32'd0);

      // R11: writes to unused offsets change nothing
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      cyc(8'h00, 1'b0, 1'b0, 0, 1'b0);
      chk("R11", bus_rdata, 32'd0);

      // R3: prescale /4 on channel 2
      wr(8'h20, 32'd0);
      wr(8'h00, 32'h4);
      idle(8, 1'b1);
      cyc(8'h20, 1'b0, 1'b1, 0, 1'b0);

      // random phase
      for (int n = 0; n < 6000; n++) begin
         int unsigned r;
         logic [7:0]  a;
         logic        we;
         logic [31:0] d;
         r  = $urandom;
         a  = offs[$urandom_range(0, 11)];
         we = (r[3:0] < 4'd5);
         d  = $urandom;
         if (a == 8'h14 || a == 8'h18) d = $urandom_range(0, 40);
         if (a == 8'h20 && r[5]) d = 32'hFFFF_FFF0 | d[3:0];
         if (a == 8'h38 && r[7:6] != 2'b00) d = 0;
         if (a == 8'h08 && r[9:8] != 2'b00) d = 0;
         cyc(a, we, r[10], d, (r[13:11] != 3'd0));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule